// File: doc/BRIEF.md
# Streaming Loop Offload Engine

This block runs an offloaded inner loop of a program on a purely combinational
kernel. Software sets a source base address, a destination base address and a
trip count through a small write-only configuration port, then writes the start
command and sleeps. For every iteration the engine fetches two operand words
from consecutive source addresses and puts them in two 32-bit operand
registers. The first register is only an input. The second is both an input and
the result holder. The kernel evaluates in one cycle and its result overwrites
the second register. The engine then stores that register to the next
destination address.

All memory traffic goes through one request port with a valid/ready handshake.
Read data returns in the same cycle the request is accepted. When the last
result has been stored, a completion flag rises. It stays up until software
issues the next start command. The kernel is chosen at elaboration. The default
kernel is a 32-bit wrapping sum of the two operands.

Top module: `loop_accel_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `done` is low and `mem_req_valid` is low.
- R2: Configuration writes select the register by `cfg_addr`: 0 sets the source base, 1 sets the destination base and 2 sets the trip count. Writing 3 with `cfg_wdata[0]`=1 is the start command.
- R3: Iteration i (counting from 0) reads the word at source+8i into the input-only register, then reads the word at source+8i+4 into the in/out register.
- R4: Iteration i stores the kernel result of that iteration's two operands to destination+4i. With the default kernel the result is (first operand + second operand) mod 2^32.
- R5: Each iteration issues exactly read, read, write, in that order. A run of N iterations issues exactly 2N reads and N writes.
- R6: While `mem_req_valid` is high and `mem_req_ready` is low, the request's address, write flag and write data hold steady, and the sequencer does not advance.
- R7: With `mem_req_ready` held high, a run of N>0 iterations takes 4 cycles per iteration. `done` becomes visible 4N cycles after the clock edge that accepts the start command.
- R8: `done` stays high, with no memory request, until the next start command is accepted.
- R9: A start command with a trip count of 0 raises `done` in the next cycle and issues no memory request.
- R10: A start command written while a run is in progress is ignored. Writes to the base or count registers during a run do not change the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr | output | 16 | Byte address of the request |
| mem_req_wdata | output | 32 | Write data (in/out register) |
| mem_rsp_rdata | input | 32 | Read data, valid in the accepting cycle |
| done | output | 1 | Completion flag |

## Verification
The bench targets a trip count of zero. A design that starts fetching anyway, or never raises the flag, would corrupt memory or leave software asleep for ever. It holds `ready` low at random to catch a sequencer that moves a request while stalled, which shows up as skipped or repeated addresses. It fires a second start command and rewrites the base and count registers in the middle of a run. An engine that restarts or picks up the new values would write to the wrong place or write the wrong number of words. It also times one-iteration and multi-iteration runs at full speed and checks that the flag stays up while the engine is idle, which catches an extra or missing state and a flag that clears itself.

// File: rtl/loopacc_pkg.sv
package loopacc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_FETCH_A = 3'd1,
      ST_FETCH_B = 3'd2,
      ST_EVAL    = 3'd3,
      ST_STORE   = 3'd4
   } seq_state_e;

   localparam logic [1:0] CFG_SRC_BASE = 2'd0;
   localparam logic [1:0] CFG_DST_BASE = 2'd1;
   localparam logic [1:0] CFG_TRIP     = 2'd2;
   localparam logic [1:0] CFG_START    = 2'd3;

   localparam int KOP_ADD = 0;
   localparam int KOP_XOR = 1;
   localparam int KOP_SUB = 2;

endpackage

// File: rtl/loopacc_cfg.sv
module loopacc_cfg
   import loopacc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [ADDR_W-1:0] src_base,
   output logic [ADDR_W-1:0] dst_base,
   output logic [CNT_W-1:0]  trip,
   output logic              start_cmd
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_base <= '0;
         dst_base <= '0;
         trip     <= '0;
      end else if (cfg_we) begin
         case (cfg_addr)
            CFG_SRC_BASE: src_base <= cfg_wdata[ADDR_W-1:0];
            CFG_DST_BASE: dst_base <= cfg_wdata[ADDR_W-1:0];
            CFG_TRIP:     trip     <= cfg_wdata[CNT_W-1:0];
            default: ;
         endcase
      end
   end

   assign start_cmd = cfg_we && (cfg_addr == CFG_START) && cfg_wdata[0];

endmodule

// File: rtl/loopacc_kernel.sv
module loopacc_kernel
   import loopacc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int OP     = KOP_ADD
) (
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   output logic [DATA_W-1:0] result
);

   generate
      if (OP == KOP_ADD) begin : g_add
         assign result = opnd_a + opnd_b;
      end else if (OP == KOP_XOR) begin : g_xor
         assign result = opnd_a ^ opnd_b;
      end else if (OP == KOP_SUB) begin : g_sub
         assign result = opnd_a - opnd_b;
      end else begin : g_bad_op
         $error("loopacc_kernel: unknown OP %0d", OP);
         assign result = '0;
      end
   endgenerate

endmodule

// File: rtl/loopacc_seq.sv
module loopacc_seq
   import loopacc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_cmd,
   input  logic [ADDR_W-1:0] src_base,
   input  logic [ADDR_W-1:0] dst_base,
   input  logic [CNT_W-1:0]  trip,
   input  logic [DATA_W-1:0] kern_out,
   output logic [DATA_W-1:0] opnd_a,
   output logic [DATA_W-1:0] opnd_b,
   output logic              req_valid,
   input  logic              req_ready,
   output logic              req_write,
   output logic [ADDR_W-1:0] req_addr,
   output logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] rsp_rdata,
   output logic              idle,
   output logic              done
);

   localparam int STEP = DATA_W / 8;
   localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(STEP);
   localparam logic [CNT_W-1:0]  ONE_LEFT  = CNT_W'(1);

   seq_state_e        state;
   logic [ADDR_W-1:0] src_ptr;
   logic [ADDR_W-1:0] dst_ptr;
   logic [CNT_W-1:0]  left;
   logic [DATA_W-1:0] reg_in;
   logic [DATA_W-1:0] reg_io;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         done    <= 1'b0;
         src_ptr <= '0;
         dst_ptr <= '0;
         left    <= '0;
         reg_in  <= '0;
         reg_io  <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start_cmd) begin
                  done    <= (trip == '0);
                  src_ptr <= src_base;
                  dst_ptr <= dst_base;
                  left    <= trip;
                  if (trip != '0) state <= ST_FETCH_A;
               end
            end
            ST_FETCH_A: begin
               if (req_ready) begin
                  reg_in  <= rsp_rdata;
                  src_ptr <= src_ptr + ADDR_STEP;
                  state   <= ST_FETCH_B;
               end
            end
            ST_FETCH_B: begin
               if (req_ready) begin
                  reg_io  <= rsp_rdata;
                  src_ptr <= src_ptr + ADDR_STEP;
                  state   <= ST_EVAL;
               end
            end
            ST_EVAL: begin
               reg_io <= kern_out;
               state  <= ST_STORE;
            end
            ST_STORE: begin
               if (req_ready) begin
                  dst_ptr <= dst_ptr + ADDR_STEP;
                  left    <= left - ONE_LEFT;
                  if (left == ONE_LEFT) begin
                     state <= ST_IDLE;
                     done  <= 1'b1;
                  end else begin
                     state <= ST_FETCH_A;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      req_valid = (state == ST_FETCH_A) || (state == ST_FETCH_B) || (state == ST_STORE);
      req_write = (state == ST_STORE);
      req_addr  = (state == ST_STORE) ? dst_ptr : src_ptr;
      req_wdata = reg_io;
      idle      = (state == ST_IDLE);
      opnd_a    = reg_in;
      opnd_b    = reg_io;
   end

endmodule

// File: rtl/loop_accel_top.sv
module loop_accel_top
   import loopacc_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 16,
   parameter int CNT_W     = 16,
   parameter int KERNEL_OP = KOP_ADD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_req_wdata,
   input  logic [DATA_W-1:0] mem_rsp_rdata,
   output logic              done
);

   generate
      if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_chk_data
         $error("loop_accel_top: DATA_W must be a whole number of bytes");
      end
      if (ADDR_W < 3 || ADDR_W > DATA_W) begin : g_chk_addr
         $error("loop_accel_top: ADDR_W out of range");
      end
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_chk_cnt
         $error("loop_accel_top: CNT_W out of range");
      end
   endgenerate

   logic [ADDR_W-1:0] cfg_src;
   logic [ADDR_W-1:0] cfg_dst;
   logic [CNT_W-1:0]  cfg_trip;
   logic              start_cmd;
   logic [DATA_W-1:0] opnd_a;
   logic [DATA_W-1:0] opnd_b;
   logic [DATA_W-1:0] kern_out;
   logic              seq_idle;

   loopacc_cfg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .src_base  (cfg_src),
      .dst_base  (cfg_dst),
      .trip      (cfg_trip),
      .start_cmd (start_cmd)
   );

   loopacc_kernel #(.DATA_W(DATA_W), .OP(KERNEL_OP)) u_kernel (
      .opnd_a (opnd_a),
      .opnd_b (opnd_b),
      .result (kern_out)
   );

   loopacc_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_cmd (start_cmd),
      .src_base  (cfg_src),
      .dst_base  (cfg_dst),
      .trip      (cfg_trip),
      .kern_out  (kern_out),
      .opnd_a    (opnd_a),
      .opnd_b    (opnd_b),
      .req_valid (mem_req_valid),
      .req_ready (mem_req_ready),
      .req_write (mem_req_write),
      .req_addr  (mem_req_addr),
      .req_wdata (mem_req_wdata),
      .rsp_rdata (mem_rsp_rdata),
      .idle      (seq_idle),
      .done      (done)
   );

endmodule

// File: rtl/loopacc_checker.sv
module loopacc_checker #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [1:0]        cfg_addr,
   input logic [DATA_W-1:0] cfg_wdata,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic              mem_req_write,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic [DATA_W-1:0] mem_req_wdata,
   input logic              done,
   input logic [CNT_W-1:0]  trip_now,
   input logic              idle
);

   localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(DATA_W / 8);

   logic              start_seen;
   logic              acc;
   logic [ADDR_W-1:0] last_wr;
   logic              have_wr;
   logic [1:0]        rd_since;

   assign start_seen = cfg_we && (cfg_addr == 2'd3) && cfg_wdata[0];
   assign acc        = mem_req_valid && mem_req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_wr  <= '0;
         have_wr  <= 1'b0;
         rd_since <= '0;
      end else if (start_seen && idle) begin
         have_wr  <= 1'b0;
         rd_since <= '0;
      end else if (acc && mem_req_write) begin
         last_wr  <= mem_req_addr;
         have_wr  <= 1'b1;
         rd_since <= '0;
      end else if (acc && rd_since != 2'd3) begin
         rd_since <= rd_since + 2'd1;
      end
   end

   assert_quiet_reset_R1: assert property (@(posedge clk)
      !rst_n |=> (!done && !mem_req_valid));

   assert_dst_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && mem_req_write && have_wr) |-> (mem_req_addr == last_wr + ADDR_STEP));

   assert_two_reads_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && mem_req_write) |-> (rd_since == 2'd2));

   assert_hold_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=>
         (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

   assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req_valid);

   assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start_seen) |=> done);

   assert_zero_trip_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_seen && idle && trip_now == '0) |=> (done && !mem_req_valid));

   assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_seen && mem_req_valid && !mem_req_ready) |=> mem_req_valid);

endmodule

bind loop_accel_top loopacc_checker #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .CNT_W  (CNT_W)
) u_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_we        (cfg_we),
   .cfg_addr      (cfg_addr),
   .cfg_wdata     (cfg_wdata),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_write (mem_req_write),
   .mem_req_addr  (mem_req_addr),
   .mem_req_wdata (mem_req_wdata),
   .done          (done),
   .trip_now      (cfg_trip),
   .idle          (seq_idle)
);

// File: tb/loop_accel_top_bench.sv
module loop_accel_top_bench;

   localparam int MEM_WORDS = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = 2'd0;
   logic [31:0] cfg_wdata = 32'd0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic        mem_req_write;
   logic [15:0] mem_req_addr;
   logic [31:0] mem_req_wdata;
   logic [31:0] mem_rsp_rdata;
   logic        done;

   logic [31:0] mem [MEM_WORDS];
   logic [31:0] expv [16];

   int checks = 0;
   int fails  = 0;
   int ready_pct = 100;
   int rd_cnt, wr_cnt, seq_err, order_err, stab_err, phase;
   logic [15:0] exp_rd_addr, exp_wr_addr;
   logic        prev_stall = 1'b0;
   logic        prev_write;
   logic [15:0] prev_addr;
   logic [31:0] prev_wdata;

   always #10 clk = ~clk;

   loop_accel_top u_loop_accel_top (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_we        (cfg_we),
      .cfg_addr      (cfg_addr),
      .cfg_wdata     (cfg_wdata),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_write (mem_req_write),
      .mem_req_addr  (mem_req_addr),
      .mem_req_wdata (mem_req_wdata),
      .mem_rsp_rdata (mem_rsp_rdata),
      .done          (done)
   );

   assign mem_rsp_rdata = mem[mem_req_addr[11:2]];

   function automatic logic [31:0] kfun(logic [31:0] a, logic [31:0] b);
      return a + b;
   endfunction

   // memory model and traffic monitor, all on the falling edge
   always @(negedge clk) begin
      logic rdy;
      rdy = (ready_pct >= 100) ? 1'b1 : (($urandom % 100) < ready_pct);
      mem_req_ready <= rdy;
      if (rst_n) begin
         if (prev_stall && !(mem_req_valid && mem_req_addr == prev_addr &&
             mem_req_write == prev_write && mem_req_wdata == prev_wdata))
            stab_err++;
         if (mem_req_valid && rdy) begin
            if (mem_req_write) begin
               if (mem_req_addr != exp_wr_addr) seq_err++;
               if (phase != 2) order_err++;
               mem[mem_req_addr[11:2]] = mem_req_wdata;
               exp_wr_addr += 16'd4;
               wr_cnt++;
               phase = 0;
            end else begin
               if (mem_req_addr != exp_rd_addr) seq_err++;
               if (phase >= 2) order_err++;
               exp_rd_addr += 16'd4;
               rd_cnt++;
               phase++;
            end
         end
      end
      prev_stall = mem_req_valid && !rdy;
      prev_addr  = mem_req_addr;
      prev_write = mem_req_write;
      prev_wdata = mem_req_wdata;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cfg_wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic prep(input int src, input int dst, input int n);
      for (int i = 0; i < 2 * n; i++) mem[(src >> 2) + i] = $urandom;
      for (int i = 0; i < n; i++) begin
         expv[i] = kfun(mem[(src >> 2) + 2 * i], mem[(src >> 2) + 2 * i + 1]);
         mem[(dst >> 2) + i] = 32'hDEAD_0000 + 32'(i);
      end
      exp_rd_addr = 16'(src); exp_wr_addr = 16'(dst);
      rd_cnt = 0; wr_cnt = 0; seq_err = 0; order_err = 0; stab_err = 0; phase = 0;
   endtask

   task automatic wait_done(output int k);
      k = 1;
      while (!done && k < 5000) begin
         @(negedge clk);
         k++;
      end
   endtask

   task automatic verify(input int dst, input int n);
      for (int i = 0; i < n; i++)
         chk(mem[(dst >> 2) + i] == expv[i], "R4 result word", mem[(dst >> 2) + i], expv[i]);
      chk(seq_err == 0, "R3 address sequence", seq_err, 0);
      chk(order_err == 0, "R5 rd-rd-wr order", order_err, 0);
      chk(rd_cnt == 2 * n && wr_cnt == n, "R5 access counts", rd_cnt * 1000 + wr_cnt, 2 * n * 1000 + n);
      chk(stab_err == 0, "R6 stalled request stable", stab_err, 0);
   endtask

   task automatic run(input int src, input int dst, input int n, input int pct, input bit timed);
      int k;
      prep(src, dst, n);
      ready_pct = pct;
      cfg_wr(2'd0, 32'(src));
      cfg_wr(2'd1, 32'(dst));
      cfg_wr(2'd2, 32'(n));
      cfg_wr(2'd3, 32'd1);
      wait_done(k);
      chk(done == 1'b1, "R2 run completes", done, 1);
      if (timed) chk(k == 4 * n + 1, "R7 cycle count", k, 4 * n + 1);
      verify(dst, n);
   endtask

   initial begin
      int k, n, src, dst, rd0, wr0;
      void'($urandom(32'h1234_5678));
      for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'(i) * 32'h9E37_79B9;
      repeat (3) @(negedge clk);
      chk(!done && !mem_req_valid, "R1 in reset", {done, mem_req_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done && !mem_req_valid, "R1 after reset", {done, mem_req_valid}, 0);

      // directed: single iteration, full speed
      run(32'h040, 32'h800, 1, 100, 1'b1);
      // directed: several iterations, full speed
      run(32'h100, 32'h880, 5, 100, 1'b1);
      // directed: carry wrap of the sum
      prep(32'h200, 32'h900, 1);
      mem[32'h200 >> 2] = 32'hFFFF_FFFF; mem[(32'h200 >> 2) + 1] = 32'h0000_0002;
      expv[0] = 32'h0000_0001;
      ready_pct = 100;
      cfg_wr(2'd0, 32'h200); cfg_wr(2'd1, 32'h900); cfg_wr(2'd2, 32'd1); cfg_wr(2'd3, 32'd1);
      wait_done(k);
      verify(32'h900, 1);

      // R8: done held, no traffic while idle
      rd0 = rd_cnt; wr0 = wr_cnt;
      repeat (12) @(negedge clk);
      chk(done == 1'b1, "R8 done held", done, 1);
      chk(rd_cnt == rd0 && wr_cnt == wr0, "R8 idle no traffic", rd_cnt + wr_cnt, rd0 + wr0);

      // R9: zero trip count
      prep(32'h300, 32'hA00, 0);
      cfg_wr(2'd2, 32'd0);
      cfg_wr(2'd3, 32'd1);
      chk(done == 1'b1, "R9 zero trip done next cycle", done, 1);
      repeat (8) @(negedge clk);
      chk(rd_cnt == 0 && wr_cnt == 0, "R9 zero trip no traffic", rd_cnt + wr_cnt, 0);

      // R2: start command with bit0 clear does nothing
      cfg_wr(2'd2, 32'd3);
      cfg_wr(2'd3, 32'd0);
      repeat (6) @(negedge clk);
      chk(done == 1'b1 && rd_cnt == 0, "R2 start needs bit0", rd_cnt, 0);

      // random runs with stalls
      for (int t = 0; t < 10; t++) begin
         n   = 1 + int'($urandom % 12);
         src = 32'h040 + 32'(($urandom % 32) * 4);
         dst = 32'h800 + 32'(($urandom % 64) * 4);
         run(src, dst, n, 30 + int'($urandom % 60), 1'b0);
      end

      // R10: start and reconfiguration while busy
      prep(32'h100, 32'hB00, 6);
      ready_pct = 50;
      cfg_wr(2'd0, 32'h100); cfg_wr(2'd1, 32'hB00); cfg_wr(2'd2, 32'd6);
      cfg_wr(2'd3, 32'd1);
      repeat (2) @(negedge clk);
      cfg_wr(2'd0, 32'h300);
      cfg_wr(2'd1, 32'hC00);
      cfg_wr(2'd2, 32'd1);
      cfg_wr(2'd3, 32'd1);
      wait_done(k);
      chk(done == 1'b1, "R10 original run completes", done, 1);
      verify(32'hB00, 6);
      chk(mem[32'hC00 >> 2] != kfun(mem[32'h300 >> 2], mem[(32'h300 >> 2) + 1]) || wr_cnt == 6,
          "R10 no second run", wr_cnt, 6);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule